// File: doc/BRIEF.md
# Interval Clock and Watchdog Unit

This block is a programmable interval timer with a watchdog on a 16-bit programmed-IO command port. Software writes a negative preset into a signed interval counter. The counter then steps up by one on each tick. A tick comes from either the line-frequency input or the external clock input, whichever is selected. When a step brings the count to zero, the unit latches an overflow, reloads the last written preset and asserts its interrupt if the mask allows it. Each counted tick also raises a one-cycle memory-increment request that carries a programmable cell address. Another block performs that memory cycle.

Every command arrives as a one-cycle strobe with a class and a 4-bit function code. The classes are control, skip, input and output. Input commands return a new accumulator value on `io_rdata` during the same cycle. Skip commands answer on `io_skip` during the same cycle. The watchdog is a separate counter that times a window set in system clock cycles and then holds a sticky timeout flag. The unit also holds an interrupt vector register and passes two banks of panel switches through to the input path.

Top module: `ivclk_top`

## Requirements
- R1: After reset, and after control function 15, the unit is in its idle state: counting is stopped, the line tick is selected, the mask is clear, no overflow is pending, the watchdog is idle without timeout, and the interval, vector and cell-address registers read 0. Class encoding is 0=control, 1=skip, 2=input, 3=output.
- R2: Control function 0 starts counting. Control function 2 stops it, and ticks that arrive while stopped leave the count unchanged.
- R3: Output function 2 writes `io_wdata` to both the count and the reload value, and input function 2 reads the count. Each counted tick adds 1. When an increment reaches zero, an overflow is latched and the count takes the reload value.
- R4: Control functions 0 and 2 both clear a pending overflow.
- R5: Control function 4 selects `line_tick` and control function 5 selects `ext_tick`. A tick on the unselected input is ignored.
- R6: `irq` equals pending overflow AND mask. Control function 13 sets the mask and control function 14 clears it.
- R7: Skip function 0 asserts `io_skip` when an overflow is pending. Skip function 2 asserts it when none is pending. Skip function 5 asserts it when the watchdog has timed out. Any other skip function gives 0.
- R8: Control function 6 clears the timeout and starts the watchdog. After WDT_CYCLES clock cycles the timeout sets and stays set. Control function 7 stops the watchdog before expiry without touching the flag.
- R9: Input function 14 returns `sw_up`. Input function 15 returns `sw_down`. Input function 9 returns `io_wdata` ORed with DEV_ID. Undecoded input functions return `io_wdata` unchanged.
- R10: Output function 11 writes the vector and output function 10 writes the cell address. Input functions 11 and 10 read them back, and both registers also drive output ports.
- R11: `mi_req` pulses for one cycle in the same cycle as each counted tick, and for no other tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| io_valid | input | 1 | Command strobe, one cycle |
| io_cls | input | 2 | Command class |
| io_func | input | 4 | Function code |
| io_wdata | input | 16 | Accumulator value presented with the command |
| io_rdata | output | 16 | New accumulator value for input commands |
| io_skip | output | 1 | Skip condition for skip commands |
| line_tick | input | 1 | Line-frequency tick pulse |
| ext_tick | input | 1 | External clock tick pulse |
| sw_up | input | 16 | Panel switches held up |
| sw_down | input | 16 | Panel switches held momentarily down |
| irq | output | 1 | Interrupt request |
| irq_vector | output | 16 | Interrupt vector address |
| mi_req | output | 1 | Memory-increment request pulse |
| mi_addr | output | 16 | Memory-increment cell address |
| wdt_timeout | output | 1 | Watchdog timed out |

## Verification
The counter is started from presets of -3 and -1. The -3 preset shows that intermediate steps raise no overflow and that the wrap reloads the preset. The -1 preset shows an immediate overflow on the first tick. Ticks are sent on the selected input, on the unselected input and while the counter is stopped, which separates source selection from run control. The watchdog is run once to expiry and once stopped early, so a sticky flag can be told apart from one that is never set.

// File: rtl/ivclk_pkg.sv
package ivclk_pkg;

    typedef enum logic [1:0] {
        CLS_CTL = 2'd0,
        CLS_SKS = 2'd1,
        CLS_INA = 2'd2,
        CLS_OTA = 2'd3
    } io_cls_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic sel_line;
        logic sel_ext;
        logic wdt_go;
        logic wdt_halt;
        logic mask_set;
        logic mask_clr;
        logic mclear;
        logic wr_cnt;
        logic wr_mia;
        logic wr_vec;
        logic sks;
        logic ina;
    } cmd_t;

endpackage

// File: rtl/ivclk_decode.sv
module ivclk_decode
    import ivclk_pkg::*;
(
    input  logic       valid,
    input  logic [1:0] cls,
    input  logic [3:0] func,
    output cmd_t       cmd
);
    logic is_ctl, is_ota;

    always_comb begin
        is_ctl       = valid && (cls == CLS_CTL);
        is_ota       = valid && (cls == CLS_OTA);
        cmd          = '0;
        cmd.start    = is_ctl && (func == 4'd0);
        cmd.stop     = is_ctl && (func == 4'd2);
        cmd.sel_line = is_ctl && (func == 4'd4);
        cmd.sel_ext  = is_ctl && (func == 4'd5);
        cmd.wdt_go   = is_ctl && (func == 4'd6);
        cmd.wdt_halt = is_ctl && (func == 4'd7);
        cmd.mask_set = is_ctl && (func == 4'd13);
        cmd.mask_clr = is_ctl && (func == 4'd14);
        cmd.mclear   = is_ctl && (func == 4'd15);
        cmd.wr_cnt   = is_ota && (func == 4'd2);
        cmd.wr_mia   = is_ota && (func == 4'd10);
        cmd.wr_vec   = is_ota && (func == 4'd11);
        cmd.sks      = valid && (cls == CLS_SKS);
        cmd.ina      = valid && (cls == CLS_INA);
    end
endmodule

// File: rtl/ivclk_tick_sel.sv
module ivclk_tick_sel #(
    parameter bit EDGE_DETECT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic ext_in,
    input  logic use_ext,
    output logic tick
);
    logic line_p, ext_p;

    generate
        if (EDGE_DETECT) begin : g_edge
            logic line_q, ext_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    line_q <= 1'b0;
                    ext_q  <= 1'b0;
                end else begin
                    line_q <= line_in;
                    ext_q  <= ext_in;
                end
            end
            assign line_p = line_in & ~line_q;
            assign ext_p  = ext_in & ~ext_q;
        end else begin : g_pulse
            assign line_p = line_in;
            assign ext_p  = ext_in;
        end
    endgenerate

    assign tick = use_ext ? ext_p : line_p;
endmodule

// File: rtl/ivclk_wdt.sv
module ivclk_wdt #(
    parameter int WDT_CYCLES = 10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic halt,
    input  logic mclear,
    output logic timeout
);
    localparam int CW = $clog2(WDT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WDT_CYCLES - 1);

    typedef struct packed {
        logic          run;
        logic          to;
        logic [CW-1:0] cnt;
    } wdt_t;

    wdt_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (mclear) begin
            s_d = '0;
        end else if (go) begin
            s_d.run = 1'b1;
            s_d.to  = 1'b0;
            s_d.cnt = '0;
        end else if (halt) begin
            s_d.run = 1'b0;
        end else if (s_q.run) begin
            if (s_q.cnt == LAST) begin
                s_d.run = 1'b0;
                s_d.to  = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign timeout = s_q.to;
endmodule

// File: rtl/ivclk_top.sv
module ivclk_top
    import ivclk_pkg::*;
#(
    parameter int          DW          = 16,
    parameter int          WDT_CYCLES  = 10_000_000,
    parameter logic [15:0] DEV_ID      = 16'h0050,
    parameter bit          EDGE_DETECT = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_valid,
    input  logic [1:0]    io_cls,
    input  logic [3:0]    io_func,
    input  logic [DW-1:0] io_wdata,
    output logic [DW-1:0] io_rdata,
    output logic          io_skip,
    input  logic          line_tick,
    input  logic          ext_tick,
    input  logic [DW-1:0] sw_up,
    input  logic [DW-1:0] sw_down,
    output logic          irq,
    output logic [DW-1:0] irq_vector,
    output logic          mi_req,
    output logic [DW-1:0] mi_addr,
    output logic          wdt_timeout
);
    localparam logic [DW-1:0] ALL_ONES = '1;

    typedef struct packed {
        logic          run;
        logic          src_ext;
        logic          mask;
        logic          pend;
        logic [DW-1:0] cnt;
        logic [DW-1:0] rld;
        logic [DW-1:0] vec;
        logic [DW-1:0] mia;
    } st_t;

    st_t  s_d, s_q;
    cmd_t cmd;
    logic tick_sel, tick;

    ivclk_decode i_decode (
        .valid (io_valid),
        .cls   (io_cls),
        .func  (io_func),
        .cmd   (cmd)
    );

    ivclk_tick_sel #(.EDGE_DETECT(EDGE_DETECT)) i_tick_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_tick),
        .ext_in  (ext_tick),
        .use_ext (s_q.src_ext),
        .tick    (tick_sel)
    );

    ivclk_wdt #(.WDT_CYCLES(WDT_CYCLES)) i_wdt (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (cmd.wdt_go),
        .halt    (cmd.wdt_halt),
        .mclear  (cmd.mclear),
        .timeout (wdt_timeout)
    );

    assign tick = tick_sel & s_q.run;

    always_comb begin
        s_d = s_q;
        if (tick) begin
            if (s_q.cnt == ALL_ONES) begin
                s_d.pend = 1'b1;
                s_d.cnt  = s_q.rld;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
        if (cmd.start) begin
            s_d.run  = 1'b1;
            s_d.pend = 1'b0;
        end
        if (cmd.stop) begin
            s_d.run  = 1'b0;
            s_d.pend = 1'b0;
        end
        if (cmd.sel_line) s_d.src_ext = 1'b0;
        if (cmd.sel_ext)  s_d.src_ext = 1'b1;
        if (cmd.mask_set) s_d.mask    = 1'b1;
        if (cmd.mask_clr) s_d.mask    = 1'b0;
        if (cmd.wr_cnt) begin
            s_d.cnt = io_wdata;
            s_d.rld = io_wdata;
        end
        if (cmd.wr_mia) s_d.mia = io_wdata;
        if (cmd.wr_vec) s_d.vec = io_wdata;
        if (cmd.mclear) s_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        io_rdata = io_wdata;
        if (cmd.ina) begin
            case (io_func)
                4'd2:    io_rdata = s_q.cnt;
                4'd9:    io_rdata = io_wdata | DW'(DEV_ID);
                4'd10:   io_rdata = s_q.mia;
                4'd11:   io_rdata = s_q.vec;
                4'd14:   io_rdata = sw_up;
                4'd15:   io_rdata = sw_down;
                default: io_rdata = io_wdata;
            endcase
        end
    end

    always_comb begin
        io_skip = 1'b0;
        if (cmd.sks) begin
            case (io_func)
                4'd0:    io_skip = s_q.pend;
                4'd2:    io_skip = ~s_q.pend;
                4'd5:    io_skip = wdt_timeout;
                default: io_skip = 1'b0;
            endcase
        end
    end

    assign irq        = s_q.pend & s_q.mask;
    assign irq_vector = s_q.vec;
    assign mi_req     = tick;
    assign mi_addr    = s_q.mia;
endmodule

// File: rtl/ivclk_checker.sv
module ivclk_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       io_valid,
    input logic [1:0] io_cls,
    input logic [3:0] io_func,
    input logic       irq,
    input logic       mi_req,
    input logic       wdt_timeout,
    input logic       running,
    input logic       pending,
    input logic       mask
);
    // R11: no memory-increment request while stopped
    a_r11_no_req_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !mi_req);

    // R4: start or stop acknowledges the overflow
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && io_cls == 2'd0 && (io_func == 4'd0 || io_func == 4'd2)) |=> !irq);

    // R6: interrupt only with the mask set
    a_r6_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask && pending));

    // R3: overflow appears only after a counted tick
    a_r3_overflow_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(mi_req));

    // R8: timeout is sticky unless restarted or cleared
    a_r8_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_timeout && !(io_valid && io_cls == 2'd0 && (io_func == 4'd6 || io_func == 4'd15)))
        |=> wdt_timeout);
endmodule

bind ivclk_top ivclk_checker i_ivclk_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_valid    (io_valid),
    .io_cls      (io_cls),
    .io_func     (io_func),
    .irq         (irq),
    .mi_req      (mi_req),
    .wdt_timeout (wdt_timeout),
    .running     (s_q.run),
    .pending     (s_q.pend),
    .mask        (s_q.mask)
);

// File: tb/test_ivclk_top.sv
`timescale 1ns/1ps
module test_ivclk_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_valid = 1'b0;
    logic [1:0]  io_cls = 2'd0;
    logic [3:0]  io_func = 4'd0;
    logic [15:0] io_wdata = 16'h0;
    logic [15:0] io_rdata;
    logic        io_skip;
    logic        line_tick = 1'b0;
    logic        ext_tick = 1'b0;
    logic [15:0] sw_up = 16'hA5A5;
    logic [15:0] sw_down = 16'h0F01;
    logic        irq;
    logic [15:0] irq_vector;
    logic        mi_req;
    logic [15:0] mi_addr;
    logic        wdt_timeout;

    int n_checks = 0;
    int n_fail = 0;
    logic [15:0] rd;
    logic        sk;

    ivclk_top #(.WDT_CYCLES(8)) i_ivclk_top (
        .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_cls(io_cls),
        .io_func(io_func), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .io_skip(io_skip), .line_tick(line_tick), .ext_tick(ext_tick),
        .sw_up(sw_up), .sw_down(sw_down), .irq(irq), .irq_vector(irq_vector),
        .mi_req(mi_req), .mi_addr(mi_addr), .wdt_timeout(wdt_timeout)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic io(input logic [1:0] c, input logic [3:0] f, input logic [15:0] w);
        @(negedge clk);
        io_valid = 1'b1; io_cls = c; io_func = f; io_wdata = w;
        #1; rd = io_rdata; sk = io_skip;
        @(posedge clk); #1;
        io_valid = 1'b0;
    endtask

    task automatic tick(input logic ext, input logic exp_req, input string req);
        @(negedge clk);
        if (ext) ext_tick = 1'b1; else line_tick = 1'b1;
        #1; check(req, {15'd0, mi_req}, {15'd0, exp_req});
        @(posedge clk); #1;
        ext_tick = 1'b0; line_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    task automatic t_reset;
        io(2'd1, 4'd0, 0); check("R1 skip0", {15'd0, sk}, 16'd0);
        io(2'd1, 4'd2, 0); check("R1 skip2", {15'd0, sk}, 16'd1);
        io(2'd2, 4'd2, 16'h1111); check("R1 count", rd, 16'h0);
        check("R1 irq", {15'd0, irq}, 16'd0);
        check("R1 wdt", {15'd0, wdt_timeout}, 16'd0);
    endtask

    task automatic t_inputs;
        io(2'd2, 4'd14, 16'h0); check("R9 up", rd, 16'hA5A5);
        io(2'd2, 4'd15, 16'h0); check("R9 down", rd, 16'h0F01);
        io(2'd2, 4'd9, 16'h0100); check("R9 id or", rd, 16'h0150);
        io(2'd2, 4'd6, 16'h7777); check("R9 undecoded", rd, 16'h7777);
        io(2'd3, 4'd11, 16'h1234); io(2'd2, 4'd11, 0); check("R10 vec", rd, 16'h1234);
        check("R10 vec port", irq_vector, 16'h1234);
        io(2'd3, 4'd10, 16'h0400); io(2'd2, 4'd10, 0); check("R10 mia", rd, 16'h0400);
        check("R10 mia port", mi_addr, 16'h0400);
    endtask

    task automatic t_interval;
        io(2'd3, 4'd2, 16'hFFFD); io(2'd0, 4'd4, 0); io(2'd0, 4'd13, 0); io(2'd0, 4'd0, 0);
        tick(1'b0, 1'b1, "R11 req"); tick(1'b0, 1'b1, "R11 req");
        io(2'd2, 4'd2, 0); check("R3 count -1", rd, 16'hFFFF);
        check("R3 no irq yet", {15'd0, irq}, 16'd0);
        tick(1'b0, 1'b1, "R11 req");
        check("R3 irq", {15'd0, irq}, 16'd1);
        io(2'd2, 4'd2, 0); check("R3 reload", rd, 16'hFFFD);
        io(2'd1, 4'd0, 0); check("R7 skip0 pending", {15'd0, sk}, 16'd1);
        io(2'd1, 4'd3, 0); check("R7 other skip", {15'd0, sk}, 16'd0);
        io(2'd0, 4'd0, 0); check("R4 ack start", {15'd0, irq}, 16'd0);
        io(2'd1, 4'd2, 0); check("R7 skip2", {15'd0, sk}, 16'd1);
    endtask

    task automatic t_stop;
        io(2'd0, 4'd2, 0);
        tick(1'b0, 1'b0, "R11 no req stopped");
        io(2'd2, 4'd2, 0); check("R2 stopped", rd, 16'hFFFD);
        io(2'd0, 4'd0, 0); tick(1'b0, 1'b1, "R11 req");
        io(2'd2, 4'd2, 0); check("R2 restarted", rd, 16'hFFFE);
    endtask

    task automatic t_source;
        io(2'd0, 4'd5, 0);
        tick(1'b0, 1'b0, "R5 line ignored");
        io(2'd2, 4'd2, 0); check("R5 line ignored", rd, 16'hFFFE);
        tick(1'b1, 1'b1, "R5 ext req");
        io(2'd2, 4'd2, 0); check("R5 ext counts", rd, 16'hFFFF);
    endtask

    task automatic t_mask;
        io(2'd0, 4'd14, 0); io(2'd3, 4'd2, 16'hFFFF);
        tick(1'b1, 1'b1, "R11 req");
        check("R6 masked", {15'd0, irq}, 16'd0);
        io(2'd1, 4'd0, 0); check("R6 pending", {15'd0, sk}, 16'd1);
        io(2'd0, 4'd13, 0); check("R6 unmasked", {15'd0, irq}, 16'd1);
        io(2'd0, 4'd2, 0); check("R4 ack stop", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_wdt;
        io(2'd0, 4'd6, 0); idle(4);
        io(2'd1, 4'd5, 0); check("R8 early", {15'd0, sk}, 16'd0);
        idle(8);
        io(2'd1, 4'd5, 0); check("R8 expired", {15'd0, sk}, 16'd1);
        check("R8 port", {15'd0, wdt_timeout}, 16'd1);
        idle(5); check("R8 sticky", {15'd0, wdt_timeout}, 16'd1);
        io(2'd0, 4'd6, 0); check("R8 restart clears", {15'd0, wdt_timeout}, 16'd0);
        idle(2); io(2'd0, 4'd7, 0); idle(20);
        io(2'd1, 4'd5, 0); check("R8 halted", {15'd0, sk}, 16'd0);
    endtask

    task automatic t_mclear;
        io(2'd0, 4'd13, 0); io(2'd0, 4'd6, 0);
        io(2'd0, 4'd15, 0);
        io(2'd2, 4'd2, 0); check("R1 mclear count", rd, 16'h0);
        io(2'd2, 4'd10, 0); check("R1 mclear mia", rd, 16'h0);
        check("R1 mclear vec", irq_vector, 16'h0);
        tick(1'b0, 1'b0, "R1 mclear stopped");
        idle(12); check("R1 mclear wdt", {15'd0, wdt_timeout}, 16'd0);
    endtask

    initial begin
        fork
            begin
                #3;
                rst_n = 1'b0;
                idle(3);
                #1 rst_n = 1'b1;
                t_reset(); t_inputs(); t_interval(); t_stop();
                t_source(); t_mask(); t_wdt(); t_mclear();
            end
            begin
                idle(20000);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule